// File: doc/BRIEF.md
# Sixteen-Source Level Interrupt Aggregator

This block collects sixteen interrupt sources into a single level-sensitive request line for a host processor. Each source has a pending bit, a capture-enable bit and a pass bit. A source that is high in a clock while its capture enable is on sets its pending bit. A pending bit whose pass bit is on holds the host request asserted. Pending bits stay set until software acknowledges them by writing ones to the status register.

Software reaches the block over a plain 16-bit register port. A write takes effect at the next rising clock edge. Read data is combinational from the current address and the registered state. Pass bits are never written directly. Two separate write addresses set or clear them, so a driver changes one source's masking without a read-modify-write. Capture enables can only be turned on. A dispatch helper reports the lowest-numbered source that is both pending and passed, both on dedicated pins and through a read-only register.

The register port carries no stream data, so it has no valid/ready handshake. The block accepts a write in every cycle and never applies back-pressure.

Top module: `ic_cascade`

## Requirements
- R1: After reset the pending, capture-enable and pass registers are all zero, `irq_o` is low and `prio_vld` is low.
- R2: A pending bit becomes 1 at a clock edge when its source input is 1 and its capture-enable bit is 1. A source whose enable bit is 0 leaves its pending bit unchanged.
- R3: A write to offset 0x04 sets every capture-enable bit written as 1. Bits written as 0 keep their value. A read of 0x04 returns the enable bits.
- R4: A write to offset 0x0C clears every pass bit written as 1, which masks those sources. Bits written as 0 keep their value.
- R5: A write to offset 0x08 sets every pass bit written as 1, which unmasks those sources. Bits written as 0 keep their value. Reads of 0x08 and of 0x0C both return the current pass bits.
- R6: A read of offset 0x00 returns the raw pending bits. A write to 0x00 clears every pending bit written as 1 and leaves the others unchanged.
- R7: When a capture and an acknowledge hit the same pending bit at the same clock edge, the bit ends up 1.
- R8: `irq_o` is 1 exactly when at least one bit is both pending and passed.
- R9: `prio_idx` gives the index of the lowest-numbered bit that is both pending and passed, and `prio_vld` is 1 when such a bit exists. When none exists, `prio_idx` is 0 and `prio_vld` is 0. A read of offset 0x10 returns the valid flag in bit 4, the index in bits 3:0, and zeros above bit 4.
- R10: The start-up sequence is: write 0xFFFF to 0x0C, then 0xFFFF to 0x04, then 0xFFFF to 0x00, with all sources low. After it, all sources are enabled, all are masked, none is pending, and `irq_o` is low.
- R11: Reads of any other offset, including unaligned ones, return 0. Writes to any other offset and to 0x10 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 16 | Interrupt source levels |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| irq_o | output | 1 | Level interrupt request to the host |
| prio_idx | output | 4 | Lowest pending, passed source index |
| prio_vld | output | 1 | `prio_idx` is meaningful |

## Verification
Two functions can hit the same pending bit in the same cycle: capture from a high, enabled source and a write-one acknowledge at offset 0x00. The bench provokes this directly by acknowledging a bit while its source is held high, and then reads the status back to confirm the bit stayed set. A randomized phase also mixes source activity with writes to every offset. A behavioural model, updated at each edge, judges every cycle's read data, request and priority outputs. That model puts capture after acknowledge, so a bit that is both captured and acknowledged ends up set.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int OFS_STAT  = 'h00;
  localparam int OFS_ENSET = 'h04;
  localparam int OFS_ALSET = 'h08;
  localparam int OFS_ALCLR = 'h0C;
  localparam int OFS_PRIO  = 'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_ENSET,
    SEL_ALSET,
    SEL_ALCLR,
    SEL_PRIO
  } reg_sel_e;
endpackage

// File: rtl/ic_capture.sv
module ic_capture #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  input  logic         en_wr,
  input  logic         ack_wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] en_o
);
  logic [N-1:0] pend_q, en_q, ack_m, hit;

  assign ack_m = ack_wr ? wdata : '0;
  assign hit   = src_i & en_q;

  // capture is applied after acknowledge: a same-edge collision leaves the bit set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= (pend_q & ~ack_m) | hit;
      if (en_wr) en_q <= en_q | wdata;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
endmodule

// File: rtl/ic_allow.sv
module ic_allow #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_wr,
  input  logic         clr_wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] allow_o
);
  logic [N-1:0] allow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      allow_q <= '0;
    else if (set_wr) allow_q <= allow_q | wdata;
    else if (clr_wr) allow_q <= allow_q & ~wdata;
  end

  assign allow_o = allow_q;
endmodule

// File: rtl/ic_lowest.sv
module ic_lowest #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          vld_o
);
  // ripple chain: seen[i] is 1 when some bit below i is set
  logic [N:0] seen;
  logic [N-1:0] first;

  assign seen[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_chain
    assign first[g]  = vec_i[g] & ~seen[g];
    assign seen[g+1] = seen[g] | vec_i[g];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (first[i]) idx_o = IW'(i);
  end

  assign vld_o = seen[N];
endmodule

// File: rtl/ic_cascade.sv
module ic_cascade
  import ic_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int AW   = 5,
  localparam int IW  = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] reg_rdata,
  output logic            irq_o,
  output logic [IW-1:0]   prio_idx,
  output logic            prio_vld
);
  reg_sel_e        sel;
  logic [NSRC-1:0] pend, en, allow, live;

  always_comb begin
    case (reg_addr)
      AW'(OFS_STAT):  sel = SEL_STAT;
      AW'(OFS_ENSET): sel = SEL_ENSET;
      AW'(OFS_ALSET): sel = SEL_ALSET;
      AW'(OFS_ALCLR): sel = SEL_ALCLR;
      AW'(OFS_PRIO):  sel = SEL_PRIO;
      default:        sel = SEL_NONE;
    endcase
  end

  ic_capture #(.N(NSRC)) u_cap (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .en_wr(reg_wr && sel == SEL_ENSET),
    .ack_wr(reg_wr && sel == SEL_STAT),
    .wdata(reg_wdata), .pend_o(pend), .en_o(en)
  );

  ic_allow #(.N(NSRC)) u_allow (
    .clk(clk), .rst_n(rst_n),
    .set_wr(reg_wr && sel == SEL_ALSET),
    .clr_wr(reg_wr && sel == SEL_ALCLR),
    .wdata(reg_wdata), .allow_o(allow)
  );

  assign live = pend & allow;

  ic_lowest #(.N(NSRC), .IW(IW)) u_low (
    .vec_i(live), .idx_o(prio_idx), .vld_o(prio_vld)
  );

  assign irq_o = |live;

  always_comb begin
    case (sel)
      SEL_STAT:             reg_rdata = pend;
      SEL_ENSET:            reg_rdata = en;
      SEL_ALSET, SEL_ALCLR: reg_rdata = allow;
      SEL_PRIO:             reg_rdata = NSRC'({prio_vld, prio_idx});
      default:              reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ic_cascade_chk.sv
module ic_cascade_chk #(
  parameter int NSRC = 16,
  parameter int AW   = 5,
  parameter int IW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_i,
  input logic            reg_wr,
  input logic [AW-1:0]   reg_addr,
  input logic [NSRC-1:0] reg_wdata,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] en,
  input logic [NSRC-1:0] allow,
  input logic            irq_o,
  input logic [IW-1:0]   prio_idx,
  input logic            prio_vld
);
  logic [NSRC-1:0] below, cap;
  assign below = (NSRC'(1) << prio_idx) - NSRC'(1);
  assign cap   = src_i & en;

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(cap)) == $past(cap)));

  p_enable_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((en & $past(en)) == $past(en)));

  p_mask_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'('h0C)) |=> ((allow & $past(reg_wdata)) == '0));

  p_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'('h08)) |=> ((allow & $past(reg_wdata)) == $past(reg_wdata)));

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'('h00)) |=> ((pend & $past(reg_wdata) & ~$past(cap)) == '0));

  p_irq_vs_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == prio_vld);

  p_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prio_vld |-> (pend[prio_idx] && allow[prio_idx] && ((pend & allow & below) == '0)));

  p_idle_index_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !prio_vld |-> (prio_idx == '0));
endmodule

bind ic_cascade ic_cascade_chk #(.NSRC(NSRC), .AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .pend(pend), .en(en),
  .allow(allow), .irq_o(irq_o), .prio_idx(prio_idx), .prio_vld(prio_vld)
);

// File: tb/ic_cascade_bench.sv
module ic_cascade_bench;
  localparam int CLK_NS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_i = '0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_o;
  logic [3:0]  prio_idx;
  logic        prio_vld;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_pend = '0, m_en = '0, m_allow = '0;

  always #(CLK_NS/2) clk = ~clk;

  ic_cascade u_ic_cascade (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .prio_idx(prio_idx), .prio_vld(prio_vld)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int m_low();
    for (int i = 0; i < 16; i++) if (m_pend[i] && m_allow[i]) return i;
    return -1;
  endfunction

  function automatic logic [15:0] m_read(input logic [4:0] a);
    int l = m_low();
    case (a)
      5'h00: return m_pend;
      5'h04: return m_en;
      5'h08, 5'h0C: return m_allow;
      5'h10: return (l < 0) ? 16'h0 : (16'h10 | 16'(l));
      default: return 16'h0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [4:0] a);
    case (a)
      5'h00: return "R6 status read";
      5'h04: return "R3 enable read";
      5'h08, 5'h0C: return "R5 pass read";
      5'h10: return "R9 priority read";
      default: return "R11 unmapped read";
    endcase
  endfunction

  task automatic compare_all();
    int l = m_low();
    check(16'(irq_o), 16'(l >= 0), "R8 irq level");
    check(16'(prio_vld), 16'(l >= 0), "R9 valid");
    check(16'(prio_idx), (l < 0) ? 16'h0 : 16'(l), "R9 index");
    check(reg_rdata, m_read(reg_addr), rd_tag(reg_addr));
  endtask

  // one clock: drive now (at a falling edge), update the model at the rising edge,
  // compare at the next falling edge
  task automatic cyc(input logic w, input logic [4:0] a, input logic [15:0] d, input logic [15:0] s);
    logic [15:0] ack;
    reg_wr = w; reg_addr = a; reg_wdata = d; src_i = s;
    @(posedge clk);
    ack = (w && a == 5'h00) ? d : 16'h0;
    m_pend = (m_pend & ~ack) | (s & m_en);
    if (w && a == 5'h04) m_en = m_en | d;
    if (w && a == 5'h08) m_allow = m_allow | d;
    if (w && a == 5'h0C) m_allow = m_allow & ~d;
    @(negedge clk);
    compare_all();
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] s);
    cyc(1'b0, a, 16'h0, s);
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: state straight after reset
    check(reg_rdata, 16'h0, "R1 status after reset");
    check(16'(irq_o), 16'h0, "R1 irq after reset");
    check(16'(prio_vld), 16'h0, "R1 valid after reset");
    rd(5'h04, 16'h0); check(reg_rdata, 16'h0, "R1 enable after reset");
    rd(5'h08, 16'h0); check(reg_rdata, 16'h0, "R1 pass after reset");

    // R2: disabled sources are not captured
    rd(5'h00, 16'hFFFF);
    rd(5'h00, 16'h0); check(reg_rdata, 16'h0, "R2 disabled source ignored");

    // R10: start-up sequence
    cyc(1'b1, 5'h0C, 16'hFFFF, 16'h0);
    cyc(1'b1, 5'h04, 16'hFFFF, 16'h0);
    cyc(1'b1, 5'h00, 16'hFFFF, 16'h0);
    rd(5'h04, 16'h0); check(reg_rdata, 16'hFFFF, "R10 all enabled");
    rd(5'h0C, 16'h0); check(reg_rdata, 16'h0, "R10 all masked");
    rd(5'h00, 16'h0); check(reg_rdata, 16'h0, "R10 none pending");
    check(16'(irq_o), 16'h0, "R10 irq low");

    // R2 capture while masked: pending but no request
    rd(5'h00, 16'h0120);
    check(reg_rdata, 16'h0120, "R2 capture");
    check(16'(irq_o), 16'h0, "R4 masked pending gives no irq");

    // R5 unmask bit 8 only, then bit 5: priority moves to 5
    cyc(1'b1, 5'h08, 16'h0100, 16'h0);
    rd(5'h10, 16'h0); check(reg_rdata, 16'h0018, "R9 index 8 valid");
    cyc(1'b1, 5'h08, 16'h0020, 16'h0);
    rd(5'h10, 16'h0); check(reg_rdata, 16'h0015, "R9 lowest wins");

    // R4 mask bit 5 again; bit 8 stays passed
    cyc(1'b1, 5'h0C, 16'h0020, 16'h0);
    rd(5'h08, 16'h0); check(reg_rdata, 16'h0100, "R4 clear only written bits");

    // R6 acknowledge bit 8, bit 5 remains pending
    cyc(1'b1, 5'h00, 16'h0100, 16'h0);
    rd(5'h00, 16'h0); check(reg_rdata, 16'h0020, "R6 ack clears written bits");
    check(16'(irq_o), 16'h0, "R8 irq drops after ack");

    // R7 capture and acknowledge collide on bit 5
    cyc(1'b1, 5'h00, 16'h0020, 16'h0020);
    rd(5'h00, 16'h0); check(reg_rdata, 16'h0020, "R7 set wins over ack");

    // R11 writes to read-only / unmapped offsets change nothing
    cyc(1'b1, 5'h10, 16'hFFFF, 16'h0);
    cyc(1'b1, 5'h14, 16'hFFFF, 16'h0);
    cyc(1'b1, 5'h01, 16'hFFFF, 16'h0);
    rd(5'h00, 16'h0); check(reg_rdata, 16'h0020, "R11 pending untouched");
    rd(5'h08, 16'h0); check(reg_rdata, 16'h0100, "R11 pass untouched");
    rd(5'h1C, 16'h0); check(reg_rdata, 16'h0, "R11 unmapped reads zero");

    // R3 enable is set-only: zeros written do not disable
    cyc(1'b1, 5'h04, 16'h0000, 16'h0);
    rd(5'h04, 16'h0); check(reg_rdata, 16'hFFFF, "R3 zeros keep enables");

    // randomized mix, judged every cycle by the model
    for (int n = 0; n < 4000; n++) begin
      logic [4:0]  a;
      logic [15:0] s;
      case ($urandom % 7)
        0: a = 5'h00; 1: a = 5'h04; 2: a = 5'h08; 3: a = 5'h0C;
        4: a = 5'h10; 5: a = 5'(($urandom % 8) * 4); default: a = 5'($urandom);
      endcase
      s = 16'($urandom) & 16'($urandom) & 16'($urandom);
      cyc(($urandom % 3) == 0, a, 16'($urandom), s);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule